// File: doc/BRIEF.md
# Staged Power-Up Sequencer

This block brings a board with many supply rails up in a fixed order. While the active-low reset is held low it stays idle and drives nothing. Once the reset is released it asserts a first domain enable. It then steps through five check stages. Each check stage raises one more enable and waits for that stage's group of power-good inputs to read all ones. Rails that came up in earlier stages stay under watch the whole time. When all groups are good, a final state reads every power-good input together and then declares the supply ready.

Any missing or dropped rail moves the machine to a single error state. That state clears every enable and is left only through reset, since recovery means removing main power. A user mode output is raised only while the supply is ready and the configuration-done input is high. The current state is exported as a 4-bit code so that a status LED driver or a board controller can follow the sequence.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is IDLE (code 0). All of `stage_en`, `pwr_ready`, `pwr_error` and `user_mode` read 0, and the block stays in IDLE for as long as reset is held.
- R2: On the first edge after reset is released, the machine enters stage 0 (code 1) with only `stage_en[0]` set. It moves to check stage 1 (code 2) on the next edge without checking any input.
- R3: Check stage k (k = 1..5, codes 2..6) drives `stage_en[k:0]` high and waits for power-good group k. Group 1 is `pg_grp1` (7 bits), group 2 is `pg_grp2` (10 bits), group 3 is `pg_grp3` (4 bits), group 4 is `pg_grp4` (3 bits) and group 5 is `pg_grp5` (5 bits). The stage advances on the first edge at which that group reads all ones. Stage 5 advances to WAIT_RDY (code 7).
- R4: If a check stage's group is not all ones at the edge that ends the TIMEOUT_CYC-th cycle spent in that stage, the machine goes to ERROR (code 9). If the group is all ones at that same edge, the stage advances instead.
- R5: In check stage k, if any group numbered below k is not all ones at an edge, the machine goes to ERROR. This check takes priority over advancing.
- R6: In WAIT_RDY (code 7), all 29 power-good bits at ones move the machine to RDY (code 8) on the next edge. Any zero bit moves it to ERROR.
- R7: In RDY, `pwr_ready` is 1 and all six enables are high. Any power-good bit at zero at an edge moves the machine to ERROR.
- R8: ERROR (code 9) is left only through reset. While in ERROR, `pwr_error` is 1 and `stage_en` and `pwr_ready` are 0.
- R9: `user_mode` equals `pwr_ready` AND `cfg_done`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; holds the machine in IDLE |
| pg_grp1 | input | 7 | Power-good bits of rail group 1 |
| pg_grp2 | input | 10 | Power-good bits of rail group 2 |
| pg_grp3 | input | 4 | Power-good bits of rail group 3 |
| pg_grp4 | input | 3 | Power-good bits of rail group 4 |
| pg_grp5 | input | 5 | Power-good bits of rail group 5 |
| cfg_done | input | 1 | Logic configuration complete |
| stage_en | output | 6 | Cumulative stage enables, bit 0 first |
| pwr_ready | output | 1 | Every rail verified and still good |
| pwr_error | output | 1 | Latched failure; main power must be removed |
| user_mode | output | 1 | Supply ready and configuration done |
| state_code | output | 4 | 0 IDLE, 1..6 stages 0..5, 7 WAIT_RDY, 8 RDY, 9 ERROR |

## Verification
The assertions assume that the power-good inputs and `cfg_done` are synchronous to `clk` and settle before each rising edge. They also assume reset is the only way out of ERROR. The bench therefore changes every input on the falling edge and holds it through the next rising edge. It releases reset only from a known IDLE state, never partway through a cycle. All rail faults are applied as whole-cycle level changes on a single bit or on whole groups, and never as glitches between edges.

// File: rtl/pwrseq_pkg.sv
// Package: shared constants and the state encoding of the power-up sequencer.
// Assumes five rail groups checked in order after one enable-only stage.
package pwrseq_pkg;

    localparam int NUM_GRP    = 5;
    localparam int NUM_STAGES = NUM_GRP + 1;
    localparam int W_G1       = 7;
    localparam int W_G2       = 10;
    localparam int W_G3       = 4;
    localparam int W_G4       = 3;
    localparam int W_G5       = 5;
    localparam int PG_TOTAL   = W_G1 + W_G2 + W_G3 + W_G4 + W_G5;
    localparam int CODE_W     = 4;

    // Bit offset of group g (0-based) inside the packed vector {g5,g4,g3,g2,g1}.
    function automatic int grp_off(input int g);
        int widths [NUM_GRP];
        int acc;
        widths = '{W_G1, W_G2, W_G3, W_G4, W_G5};
        acc = 0;
        for (int i = 0; i < g; i++) begin
            acc += widths[i];
        end
        return acc;
    endfunction

    // Width of group g (0-based).
    function automatic int grp_width(input int g);
        int widths [NUM_GRP];
        widths = '{W_G1, W_G2, W_G3, W_G4, W_G5};
        return widths[g];
    endfunction

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE  = 4'd0,
        ST_EN0   = 4'd1,
        ST_G1    = 4'd2,
        ST_G2    = 4'd3,
        ST_G3    = 4'd4,
        ST_G4    = 4'd5,
        ST_G5    = 4'd6,
        ST_WAIT  = 4'd7,
        ST_RDY   = 4'd8,
        ST_ERR   = 4'd9
    } seq_state_e;

endpackage

// File: rtl/pwrseq_pg_eval.sv
// Module: reduces the packed power-good vector to per-group "all good" flags
// and running prefix flags (groups 0..k all good). Purely combinational.
// Assumes inputs are already synchronous to the sequencer clock.
module pwrseq_pg_eval
    import pwrseq_pkg::*;
(
    input  logic [PG_TOTAL-1:0] pg_all,
    output logic [NUM_GRP-1:0]  grp_ok,
    output logic [NUM_GRP-1:0]  upto_ok
);

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam int OFF = grp_off(g);
            localparam int WID = grp_width(g);
            // Group g is good only when every bit of its slice is high.
            assign grp_ok[g] = &pg_all[OFF +: WID];
            if (g == 0) begin : g_first
                // First prefix equals the first group.
                assign upto_ok[g] = grp_ok[g];
            end else begin : g_rest
                // Prefix chains the previous prefix with this group.
                assign upto_ok[g] = upto_ok[g-1] & grp_ok[g];
            end
        end
    endgenerate

endmodule

// File: rtl/pwrseq_timer.sv
// Module: stage timeout counter. Counts cycles while run is high and flags
// expiry on the last allowed cycle. Cleared on reset or whenever clr is high.
// Assumes TIMEOUT_CYC >= 2.
module pwrseq_timer #(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter for the current stage, saturating at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry flag: the current cycle is the final one allowed in the stage.
    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/pwrseq_fsm.sv
// Module: sequencing state machine. Walks IDLE -> stage 0 -> check stages
// 1..5 -> WAIT_RDY -> RDY, with any rail fault or timeout latching ERROR.
// Assumes synchronous active-low reset and group flags from pwrseq_pg_eval.
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_ok,
    input  logic [NUM_GRP-1:0] upto_ok,
    input  logic               tmr_expired,
    output seq_state_e         state,
    output logic               tmr_clr,
    output logic               tmr_run
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       cur_ok;
    logic       prior_ok;
    logic       chk_stage;
    seq_state_e adv_state;

    // Select the group under test, the earlier-group prefix and the successor.
    always_comb begin
        cur_ok    = 1'b0;
        prior_ok  = 1'b1;
        chk_stage = 1'b1;
        adv_state = ST_ERR;
        case (state_q)
            ST_G1: begin
                cur_ok    = grp_ok[0];
                adv_state = ST_G2;
            end
            ST_G2: begin
                cur_ok    = grp_ok[1];
                prior_ok  = upto_ok[0];
                adv_state = ST_G3;
            end
            ST_G3: begin
                cur_ok    = grp_ok[2];
                prior_ok  = upto_ok[1];
                adv_state = ST_G4;
            end
            ST_G4: begin
                cur_ok    = grp_ok[3];
                prior_ok  = upto_ok[2];
                adv_state = ST_G5;
            end
            ST_G5: begin
                cur_ok    = grp_ok[4];
                prior_ok  = upto_ok[3];
                adv_state = ST_WAIT;
            end
            default: chk_stage = 1'b0;
        endcase
    end

    // Next-state logic: earlier-group loss beats advance, advance beats timeout.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: state_d = ST_EN0;
            ST_EN0:  state_d = ST_G1;
            ST_G1, ST_G2, ST_G3, ST_G4, ST_G5: begin
                if (!prior_ok) begin
                    state_d = ST_ERR;
                end else if (cur_ok) begin
                    state_d = adv_state;
                end else if (tmr_expired) begin
                    state_d = ST_ERR;
                end
            end
            ST_WAIT: state_d = upto_ok[NUM_GRP-1] ? ST_RDY : ST_ERR;
            ST_RDY:  state_d = upto_ok[NUM_GRP-1] ? ST_RDY : ST_ERR;
            ST_ERR:  state_d = ST_ERR;
            default: state_d = ST_ERR;
        endcase
    end

    // State register; reset forces IDLE and holds it while low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer control: run inside check stages, restart on every transition.
    assign tmr_run = chk_stage;
    assign tmr_clr = (state_d != state_q);
    assign state   = state_q;

endmodule

// File: rtl/pwrseq_outdec.sv
// Module: decodes the registered state into enables, flags and the state code.
// Enables are cumulative: stage k's enable stays on through RDY. Assumes the
// state encoding of pwrseq_pkg, where stage k has code k+1.
module pwrseq_outdec
    import pwrseq_pkg::*;
(
    input  seq_state_e              state,
    input  logic                    cfg_done,
    output logic [NUM_STAGES-1:0]   stage_en,
    output logic                    pwr_ready,
    output logic                    pwr_error,
    output logic                    user_mode,
    output logic [CODE_W-1:0]       state_code
);

    genvar k;
    generate
        for (k = 0; k < NUM_STAGES; k++) begin : g_en
            localparam logic [CODE_W-1:0] FIRST = CODE_W'(k + 1);
            // Enable k is on from its own stage up to and including RDY.
            assign stage_en[k] = (state >= FIRST) && (state <= ST_RDY);
        end
    endgenerate

    // Status flags and user mode gating.
    assign pwr_ready  = (state == ST_RDY);
    assign pwr_error  = (state == ST_ERR);
    assign user_mode  = pwr_ready && cfg_done;
    assign state_code = state;

endmodule

// File: rtl/pwrseq_top.sv
// Module: top of the staged power-up sequencer. Packs the rail groups, then
// wires the evaluator, stage timer, state machine and output decoder.
// Assumes all inputs are synchronous to clk; TIMEOUT_CYC >= 2.
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W_G1-1:0]       pg_grp1,
    input  logic [W_G2-1:0]       pg_grp2,
    input  logic [W_G3-1:0]       pg_grp3,
    input  logic [W_G4-1:0]       pg_grp4,
    input  logic [W_G5-1:0]       pg_grp5,
    input  logic                  cfg_done,
    output logic [NUM_STAGES-1:0] stage_en,
    output logic                  pwr_ready,
    output logic                  pwr_error,
    output logic                  user_mode,
    output logic [CODE_W-1:0]     state_code
);

    logic [PG_TOTAL-1:0] pg_all;
    logic [NUM_GRP-1:0]  grp_ok;
    logic [NUM_GRP-1:0]  upto_ok;
    logic                tmr_clr;
    logic                tmr_run;
    logic                tmr_expired;
    seq_state_e          state;

    // Pack groups with group 1 in the low bits.
    assign pg_all = {pg_grp5, pg_grp4, pg_grp3, pg_grp2, pg_grp1};

    pwrseq_pg_eval u_eval (
        .pg_all  (pg_all),
        .grp_ok  (grp_ok),
        .upto_ok (upto_ok)
    );

    pwrseq_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    pwrseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_ok      (grp_ok),
        .upto_ok     (upto_ok),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run)
    );

    pwrseq_outdec u_out (
        .state      (state),
        .cfg_done   (cfg_done),
        .stage_en   (stage_en),
        .pwr_ready  (pwr_ready),
        .pwr_error  (pwr_error),
        .user_mode  (user_mode),
        .state_code (state_code)
    );

endmodule

// File: rtl/pwrseq_chk.sv
// Module: protocol checker for pwrseq_top, attached through bind below.
// Relates the top-level ports over time; contains no design logic.
module pwrseq_chk
    import pwrseq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [W_G1-1:0]       pg_grp1,
    input logic [W_G2-1:0]       pg_grp2,
    input logic [W_G3-1:0]       pg_grp3,
    input logic [W_G4-1:0]       pg_grp4,
    input logic [W_G5-1:0]       pg_grp5,
    input logic                  cfg_done,
    input logic [NUM_STAGES-1:0] stage_en,
    input logic                  pwr_ready,
    input logic                  pwr_error,
    input logic                  user_mode,
    input logic [CODE_W-1:0]     state_code
);

    logic all_good;
    logic cur_good;

    // Reference view of the rails, taken from the ports.
    assign all_good = (&pg_grp1) && (&pg_grp2) && (&pg_grp3) && (&pg_grp4) && (&pg_grp5);

    // Group under test for the current check-stage code.
    always_comb begin
        case (state_code)
            4'd2:    cur_good = &pg_grp1;
            4'd3:    cur_good = &pg_grp2;
            4'd4:    cur_good = &pg_grp3;
            4'd5:    cur_good = &pg_grp4;
            4'd6:    cur_good = &pg_grp5;
            default: cur_good = 1'b1;
        endcase
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (state_code == 4'd0) && (stage_en == '0)); // R1

    AST_EN0_TO_G1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd1) |=> (state_code == 4'd2)); // R2

    AST_NO_EARLY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code >= 4'd2) && (state_code <= 4'd6) && !cur_good)
        |=> ((state_code == $past(state_code)) || (state_code == 4'd9))); // R3

    AST_WAIT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 4'd7) && !all_good) |=> (state_code == 4'd9)); // R6

    AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 4'd8) && !all_good) |=> (state_code == 4'd9)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'd9) |=> (state_code == 4'd9)); // R8

    AST_ERR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_error |-> ((stage_en == '0) && !pwr_ready)); // R8

    AST_USER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> (pwr_ready && cfg_done)); // R9

endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pg_grp1    (pg_grp1),
    .pg_grp2    (pg_grp2),
    .pg_grp3    (pg_grp3),
    .pg_grp4    (pg_grp4),
    .pg_grp5    (pg_grp5),
    .cfg_done   (cfg_done),
    .stage_en   (stage_en),
    .pwr_ready  (pwr_ready),
    .pwr_error  (pwr_error),
    .user_mode  (user_mode),
    .state_code (state_code)
);

// File: tb/pwrseq_top_tb.sv
// Bench: table-driven walk through a normal bring-up and a rail drop, then
// directed tests for timeout, late arrival, earlier-group loss and reset.
module pwrseq_top_tb_top;

    localparam int T_OUT = 8;
    localparam int NVEC  = 13;
    localparam logic [28:0] PG_ALL = 29'h1FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [28:0] pg;
    logic        cfg_done;
    logic [5:0]  stage_en;
    logic        pwr_ready;
    logic        pwr_error;
    logic        user_mode;
    logic [3:0]  state_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10ns clk = ~clk;

    pwrseq_top #(.TIMEOUT_CYC(T_OUT)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_grp1    (pg[6:0]),
        .pg_grp2    (pg[16:7]),
        .pg_grp3    (pg[20:17]),
        .pg_grp4    (pg[23:21]),
        .pg_grp5    (pg[28:24]),
        .cfg_done   (cfg_done),
        .stage_en   (stage_en),
        .pwr_ready  (pwr_ready),
        .pwr_error  (pwr_error),
        .user_mode  (user_mode),
        .state_code (state_code)
    );

    // Vector: {rst_n, cfg_done, pg[28:0], expected code[3:0], requirement[3:0]}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 29'h0,         4'd0, 4'd1}, // R1 reset -> IDLE
        {1'b1, 1'b0, 29'h0,         4'd1, 4'd2}, // R2 stage 0
        {1'b1, 1'b0, 29'h0,         4'd2, 4'd3}, // R3 waits in check stage 1
        {1'b1, 1'b0, 29'h7F,        4'd3, 4'd3}, // R3 group 1 good
        {1'b1, 1'b0, 29'h1FFFF,     4'd4, 4'd3}, // R3 group 2 good
        {1'b1, 1'b0, 29'h1FFFFF,    4'd5, 4'd3}, // R3 group 3 good
        {1'b1, 1'b0, 29'hFFFFFF,    4'd6, 4'd3}, // R3 group 4 good
        {1'b1, 1'b0, PG_ALL,        4'd7, 4'd3}, // R3 group 5 good -> WAIT_RDY
        {1'b1, 1'b0, PG_ALL,        4'd8, 4'd6}, // R6 all good -> RDY, no user
        {1'b1, 1'b1, PG_ALL,        4'd8, 4'd9}, // R9 user mode with cfg_done
        {1'b1, 1'b1, 29'h1FFDFFFF,  4'd9, 4'd7}, // R7 drop in RDY -> ERROR
        {1'b1, 1'b1, PG_ALL,        4'd9, 4'd8}, // R8 error is sticky
        {1'b0, 1'b1, PG_ALL,        4'd0, 4'd1}  // R1 reset leaves ERROR
    };

    // Expected enables from the state code, per R2, R3, R7 and R8.
    function automatic logic [5:0] exp_en(input logic [3:0] code);
        int n;
        if (code == 4'd0 || code >= 4'd9) return 6'd0;
        n = (code > 4'd6) ? 6 : int'(code);
        return 6'((1 << n) - 1);
    endfunction

    // Compare every output against the model for one expected code.
    task automatic check(input logic [3:0] code, input int req);
        logic [5:0] e_en;
        logic       e_rdy;
        logic       e_err;
        logic       e_usr;
        e_en  = exp_en(code);
        e_rdy = (code == 4'd8);
        e_err = (code == 4'd9);
        e_usr = e_rdy && cfg_done;
        n_chk++;
        if (state_code !== code || stage_en !== e_en || pwr_ready !== e_rdy ||
            pwr_error !== e_err || user_mode !== e_usr) begin
            n_fail++;
            $display("FAIL R%0d: code=%0d en=%b rdy=%b err=%b usr=%b expected code=%0d en=%b rdy=%b err=%b usr=%b",
                     req, state_code, stage_en, pwr_ready, pwr_error, user_mode,
                     code, e_en, e_rdy, e_err, e_usr);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20ns * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        pg       = '0;
        cfg_done = 1'b0;
        @(negedge clk);

        // Table walk: apply vector on the falling edge, check after the rising one.
        for (int i = 0; i < NVEC; i++) begin
            rst_n    = VEC[i][38];
            cfg_done = VEC[i][37];
            pg       = VEC[i][36:8];
            tick();
            check(VEC[i][7:4], int'(VEC[i][3:0]));
        end

        // R4 timeout: group 1 never arrives.
        cfg_done = 1'b0;
        pg = '0;
        do_reset();
        tick(); check(4'd1, 2);
        tick(); check(4'd2, 4);
        for (int c = 0; c < T_OUT - 1; c++) tick();
        check(4'd2, 4);                  // R4 still waiting at last allowed cycle
        tick(); check(4'd9, 4);          // R4 timeout -> ERROR

        // R4 late arrival on the final allowed cycle advances.
        pg = '0;
        do_reset();
        tick(); tick();
        for (int c = 0; c < T_OUT - 1; c++) tick();
        check(4'd2, 4);
        pg = 29'h7F;
        tick(); check(4'd3, 4);          // R4 advances on last cycle

        // R5 an earlier group drops in a later stage.
        pg = 29'h1FFFF;
        tick(); check(4'd4, 5);
        pg = 29'h1FFFE;                  // group 1 bit 0 lost
        tick(); check(4'd9, 5);          // R5 -> ERROR

        // R6 a rail lost while in WAIT_RDY.
        pg = PG_ALL;
        do_reset();
        for (int c = 0; c < 7; c++) tick();
        check(4'd7, 6);
        pg = 29'h0FFF_FFFF;              // group 5 top bit lost
        tick(); check(4'd9, 6);          // R6 -> ERROR

        // R1 reset mid-sequence returns to IDLE and holds there.
        pg = PG_ALL;
        do_reset();
        tick(); tick(); tick();
        check(4'd3, 3);
        rst_n = 1'b0;
        tick(); check(4'd0, 1);
        tick(); check(4'd0, 1);          // R1 held while low

        finish_run();
    end

endmodule